// File: doc/BRIEF.md
# Machine trap and status-register controller

This block is the trap controller of a small 32-bit RISC-V core. It holds four machine registers: an interrupt-enable status word, a trap cause, a saved exception address and a trap vector. The pipeline presents one decoded instruction per cycle. The block takes the instruction's PC, a CSR access request and flags for ecall, ebreak, illegal opcode and mret. It also watches a level-sensitive external interrupt line. It decides whether the instruction traps, returns from a trap or updates a CSR. For the CSR access it returns the read value in the same cycle.

Each register can be reached at a writable address and at a read-only alias. A swap instruction (csrrw) is the only CSR access the block accepts. Any other CSR operation, and any address outside the eight mapped ones, becomes an illegal-instruction trap. When a trap or a return is accepted, the block raises a one-cycle redirect strobe together with the new fetch address, one clock after the request. After reset it also raises the strobe with the reset fetch address, which starts the core.

Top module: `trap_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, redirect_o is 1 and redirect_pc_o equals RESET_PC (default 0x00000000). Reset clears the enable bit, the saved-enable bit, the cause register and the exception address, and loads the vector register with TRAP_VEC (default 0x00000010).
- R2: Reading the status register gives the enable bit in bit 0, the saved enable in bit 1 and the live level of ext_irq_i in bit 2. Bits 31 to 3 read as zero.
- R3: A valid csrrw (csr_req_i=1, csr_rw_i=1) to a writable address (0x7C0 status, 0x7C1 cause, 0x7C2 exception address, 0x7C3 vector) returns the old value on csr_rdata_o in the same cycle and stores csr_wdata_i at the next edge. Status keeps only bits 1 to 0. Cause keeps only bit 31 and bits 3 to 0.
- R4: A csrrw to a read-only alias (0xFC0 to 0xFC3, in the same register order) returns the register value and changes no state.
- R5: The low two bits of the exception address and of the vector register are always zero, because writes clear them.
- R6: A valid CSR request with csr_rw_i=0, or with an address outside the eight mapped ones, traps with cause 0x00000002. In that case csr_rdata_o is 0, and it is also 0 whenever no valid, mapped csrrw is presented.
- R7: On any accepted trap, the saved-enable bit takes the old enable bit and the enable bit clears. In the next cycle redirect_o is 1 and redirect_pc_o holds the vector register value as it was before the trap.
- R8: The trap cause is written as 0x8000000B for an external interrupt, 0x00000002 for an illegal instruction, 0x00000003 for ebreak and 0x0000000B for ecall.
- R9: The exception address is loaded with pc_i of the trapping instruction. For software traps this is the faulting instruction. For an external interrupt it is the instruction that was cancelled, which is therefore the resume address.
- R10: An external interrupt is accepted only on a valid cycle with ext_irq_i=1 while the enable bit is 1. ecall and ebreak trap regardless of the enable bit.
- R11: A synchronous trap has priority over a pending enabled interrupt. Among synchronous causes, illegal (including a bad CSR access) beats ebreak, and ebreak beats ecall.
- R12: A valid mret that does not trap copies the saved-enable bit into the enable bit. In the next cycle redirect_o is 1 and redirect_pc_o holds the exception address.
- R13: An instruction that traps has no other effect: its CSR write and its mret are dropped. With valid_i=0 nothing changes and redirect_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_i | input | 1 | Level of the external interrupt request |
| valid_i | input | 1 | An instruction is presented this cycle |
| pc_i | input | 32 | Address of the presented instruction |
| csr_req_i | input | 1 | The instruction is a CSR access |
| csr_rw_i | input | 1 | The CSR access is a swap (csrrw) |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | Value to write into the CSR |
| ecall_i | input | 1 | The instruction is ecall |
| ebreak_i | input | 1 | The instruction is ebreak |
| illegal_i | input | 1 | The decoder found an unknown opcode |
| mret_i | input | 1 | The instruction is mret |
| csr_rdata_o | output | 32 | Old value of the accessed CSR |
| redirect_o | output | 1 | Fetch must restart at redirect_pc_o |
| redirect_pc_o | output | 32 | New fetch address |

## Verification
The hardest case to reach is a collision. This is a cycle where an enabled interrupt is pending while the presented instruction is a CSR write, an mret or itself a synchronous trap. It can only happen after software has set the enable bit through a status write, and after no trap has since cleared that bit. The stimulus writes the enable bit directly, then presents colliding instructions. The random phase also writes the status register often and keeps the interrupt line high about a third of the time, so enabled collisions recur throughout the run.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int unsigned XW = 32;
    localparam int unsigned AW = 12;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_EVEC   = 2'd3
    } csr_sel_e;

    localparam logic [XW-1:0] CAUSE_EXT     = 32'h8000_000B;
    localparam logic [XW-1:0] CAUSE_ILLEGAL = 32'h0000_0002;
    localparam logic [XW-1:0] CAUSE_EBREAK  = 32'h0000_0003;
    localparam logic [XW-1:0] CAUSE_ECALL   = 32'h0000_000B;

    localparam logic [XW-1:0] CAUSE_KEEP = 32'h8000_000F;
    localparam logic [XW-1:0] WORD_ALIGN = 32'hFFFF_FFFC;

    typedef struct packed {
        logic          en;
        logic          prev;
        logic [XW-1:0] cause;
        logic [XW-1:0] epc;
        logic [XW-1:0] evec;
        logic          redir;
        logic [XW-1:0] redir_pc;
    } trap_state_t;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import trap_pkg::*;
#(
    parameter logic [AW-1:0] CSR_BASE = 12'h7C0
) (
    input  logic [AW-1:0] addr_i,
    output logic          hit_o,
    output logic          ro_o,
    output csr_sel_e      sel_o
);
    // Writable block sits at CSR_BASE, read-only alias differs only in bit 11.
    localparam logic [AW-4:0] BLOCK_ID = CSR_BASE[AW-2:2];

    always_comb begin
        hit_o = (addr_i[AW-2:2] == BLOCK_ID);
        ro_o  = addr_i[AW-1];
        sel_o = csr_sel_e'(addr_i[1:0]);
    end

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic          valid_i,
    input  logic          bad_csr_i,
    input  logic          illegal_i,
    input  logic          ebreak_i,
    input  logic          ecall_i,
    input  logic          irq_line_i,
    input  logic          irq_en_i,
    input  logic          mret_i,
    output logic          take_trap_o,
    output logic          take_mret_o,
    output logic          commit_o,
    output logic [XW-1:0] cause_o
);
    logic sync_ill;
    logic sync_any;
    logic irq_go;

    always_comb begin
        sync_ill    = illegal_i | bad_csr_i;
        sync_any    = sync_ill | ebreak_i | ecall_i;
        irq_go      = irq_line_i & irq_en_i & ~sync_any;
        take_trap_o = valid_i & (sync_any | irq_go);
        take_mret_o = valid_i & mret_i & ~take_trap_o;
        commit_o    = valid_i & ~take_trap_o;

        if (sync_ill)      cause_o = CAUSE_ILLEGAL;
        else if (ebreak_i) cause_o = CAUSE_EBREAK;
        else if (ecall_i)  cause_o = CAUSE_ECALL;
        else               cause_o = CAUSE_EXT;
    end

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] TRAP_VEC = 32'h0000_0010,
    parameter logic [11:0] CSR_BASE = 12'h7C0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_irq_i,
    input  logic        valid_i,
    input  logic [31:0] pc_i,
    input  logic        csr_req_i,
    input  logic        csr_rw_i,
    input  logic [11:0] csr_addr_i,
    input  logic [31:0] csr_wdata_i,
    input  logic        ecall_i,
    input  logic        ebreak_i,
    input  logic        illegal_i,
    input  logic        mret_i,
    output logic [31:0] csr_rdata_o,
    output logic        redirect_o,
    output logic [31:0] redirect_pc_o
);
    localparam trap_state_t RST_STATE = '{
        en:       1'b0,
        prev:     1'b0,
        cause:    '0,
        epc:      '0,
        evec:     TRAP_VEC & WORD_ALIGN,
        redir:    1'b1,
        redir_pc: RESET_PC
    };

    trap_state_t st_d, st_q;

    logic          addr_hit;
    logic          addr_ro;
    csr_sel_e      addr_sel;
    logic          bad_csr;
    logic          csr_swap;
    logic          take_trap;
    logic          take_mret;
    logic          commit;
    logic [XW-1:0] cause_n;
    logic [XW-1:0] sel_val;

    csr_addr_decode #(.CSR_BASE(CSR_BASE)) u_dec (
        .addr_i (csr_addr_i),
        .hit_o  (addr_hit),
        .ro_o   (addr_ro),
        .sel_o  (addr_sel)
    );

    always_comb begin
        bad_csr  = csr_req_i & (~csr_rw_i | ~addr_hit);
        csr_swap = valid_i & csr_req_i & csr_rw_i & addr_hit;
    end

    trap_arbiter u_arb (
        .valid_i     (valid_i),
        .bad_csr_i   (bad_csr),
        .illegal_i   (illegal_i),
        .ebreak_i    (ebreak_i),
        .ecall_i     (ecall_i),
        .irq_line_i  (ext_irq_i),
        .irq_en_i    (st_q.en),
        .mret_i      (mret_i),
        .take_trap_o (take_trap),
        .take_mret_o (take_mret),
        .commit_o    (commit),
        .cause_o     (cause_n)
    );

    // Read path: current register contents, status carries the live line.
    always_comb begin
        case (addr_sel)
            SEL_STATUS: sel_val = {29'd0, ext_irq_i, st_q.prev, st_q.en};
            SEL_CAUSE:  sel_val = st_q.cause;
            SEL_EPC:    sel_val = st_q.epc;
            default:    sel_val = st_q.evec;
        endcase
        csr_rdata_o = csr_swap ? sel_val : '0;
    end

    always_comb begin
        st_d       = st_q;
        st_d.redir = 1'b0;
        if (take_trap) begin
            st_d.prev     = st_q.en;
            st_d.en       = 1'b0;
            st_d.cause    = cause_n;
            st_d.epc      = pc_i & WORD_ALIGN;
            st_d.redir    = 1'b1;
            st_d.redir_pc = st_q.evec;
        end else if (take_mret) begin
            st_d.en       = st_q.prev;
            st_d.redir    = 1'b1;
            st_d.redir_pc = st_q.epc;
        end else if (commit && csr_swap && !addr_ro) begin
            case (addr_sel)
                SEL_STATUS: begin
                    st_d.en   = csr_wdata_i[0];
                    st_d.prev = csr_wdata_i[1];
                end
                SEL_CAUSE: st_d.cause = csr_wdata_i & CAUSE_KEEP;
                SEL_EPC:   st_d.epc   = csr_wdata_i & WORD_ALIGN;
                default:   st_d.evec  = csr_wdata_i & WORD_ALIGN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign redirect_o    = st_q.redir;
    assign redirect_pc_o = st_q.redir_pc;

    // R7: trap saves and clears the enable, then steers fetch to the old vector
    a_r7_trap_saves_enable: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (!st_q.en && st_q.prev == $past(st_q.en)
                       && redirect_o && redirect_pc_o == $past(st_q.evec)));

    // R12: return restores the enable and resumes at the saved address
    a_r12_mret_restores: assert property (@(posedge clk) disable iff (!rst_n)
        take_mret |=> (st_q.en == $past(st_q.prev) && redirect_o
                       && redirect_pc_o == $past(st_q.epc)));

    // R10: an interrupt cause is only produced while enabled
    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && cause_n[31]) |-> st_q.en);

    // R11: a synchronous cause never records as an interrupt
    a_r11_sync_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (ecall_i || ebreak_i || illegal_i)) |=> (redirect_o && !st_q.cause[31]));

    // R5: saved addresses stay word aligned
    a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.epc[1:0] == 2'b00) && (st_q.evec[1:0] == 2'b00));

    // R4: an access through the read-only alias leaves all registers as they were
    a_r4_alias_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_swap && addr_ro && !take_trap) |=>
            ($stable(st_q.en) && $stable(st_q.prev) && $stable(st_q.cause)
             && $stable(st_q.epc) && $stable(st_q.evec)));

    // R13: idle cycles never redirect
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !redirect_o);

endmodule

// File: tb/trap_ctrl_test.sv
`timescale 1ns/1ps
module trap_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_irq_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic        csr_req_i = 1'b0;
    logic        csr_rw_i = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic        ecall_i = 1'b0;
    logic        ebreak_i = 1'b0;
    logic        illegal_i = 1'b0;
    logic        mret_i = 1'b0;
    logic [31:0] csr_rdata_o;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;

    trap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq_i), .valid_i(valid_i),
        .pc_i(pc_i), .csr_req_i(csr_req_i), .csr_rw_i(csr_rw_i),
        .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i),
        .ecall_i(ecall_i), .ebreak_i(ebreak_i), .illegal_i(illegal_i),
        .mret_i(mret_i), .csr_rdata_o(csr_rdata_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model
    logic        m_en = 1'b0, m_prev = 1'b0;
    logic [31:0] m_cause = '0, m_epc = '0, m_evec = 32'h10;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic mapped(input logic [11:0] a);
        return (a >= 12'h7C0 && a <= 12'h7C3) || (a >= 12'hFC0 && a <= 12'hFC3);
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a, input logic line);
        case (a[1:0])
            2'd0:    return {29'd0, line, m_prev, m_en};
            2'd1:    return m_cause;
            2'd2:    return m_epc;
            default: return m_evec;
        endcase
    endfunction

    // drive one instruction at a falling edge, check read data, then the redirect
    task automatic op(input logic v, input logic csr, input logic rw, input logic [11:0] a,
                      input logic [31:0] wd, input logic ec, input logic eb, input logic il,
                      input logic mr, input logic irq, input logic [31:0] pc, input string tag);
        logic bad, sync, irqgo, trap, mgo, wr;
        logic [31:0] cause, tgt, exp_rd;
        valid_i = v; csr_req_i = csr; csr_rw_i = rw; csr_addr_i = a; csr_wdata_i = wd;
        ecall_i = ec; ebreak_i = eb; illegal_i = il; mret_i = mr; ext_irq_i = irq; pc_i = pc;
        #1;
        bad   = csr && (!rw || !mapped(a));
        sync  = il || bad || eb || ec;
        irqgo = irq && m_en && !sync;
        trap  = v && (sync || irqgo);
        mgo   = v && mr && !trap;
        wr    = v && csr && rw && mapped(a) && !a[11] && !trap;
        exp_rd = (v && csr && rw && mapped(a)) ? model_read(a, irq) : 32'h0;
        chk({tag, " rdata"}, csr_rdata_o, exp_rd);
        cause = (il || bad) ? 32'h2 : eb ? 32'h3 : ec ? 32'hB : 32'h8000_000B;
        tgt = trap ? m_evec : m_epc;
        if (trap) begin
            m_prev = m_en; m_en = 1'b0; m_cause = cause; m_epc = pc;
        end else if (mgo) begin
            m_en = m_prev;
        end else if (wr) begin
            case (a[1:0])
                2'd0: begin m_en = wd[0]; m_prev = wd[1]; end
                2'd1: m_cause = wd & 32'h8000_000F;
                2'd2: m_epc = wd & 32'hFFFF_FFFC;
                default: m_evec = wd & 32'hFFFF_FFFC;
            endcase
        end
        @(posedge clk); #1;
        chk({tag, " redirect"}, {31'd0, redirect_o}, {31'd0, trap || mgo});
        if (trap || mgo) chk({tag, " target"}, redirect_pc_o, tgt);
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        op(1, 1, 1, a, 32'h0, 0, 0, 0, 0, 0, 32'h40, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        op(1, 1, 1, a, d, 0, 0, 0, 0, 0, 32'h44, tag);
    endtask

    task automatic chk_regs(input string tag);
        logic [31:0] exp;
        for (int i = 0; i < 4; i++) begin
            valid_i = 1; csr_req_i = 1; csr_rw_i = 1; csr_addr_i = 12'hFC0 + 12'(i);
            ecall_i = 0; ebreak_i = 0; illegal_i = 0; mret_i = 0; ext_irq_i = 0;
            #1;
            exp = model_read(12'hFC0 + 12'(i), 1'b0);
            chk(tag, csr_rdata_o, exp);
        end
        valid_i = 0; csr_req_i = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        // R1 reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 redirect in reset", {31'd0, redirect_o}, 32'd1);
        chk("R1 reset pc", redirect_pc_o, 32'h0);
        chk_regs("R1 reset regs");
        rst_n = 1'b1;
        #1;
        chk("R1 redirect after release", {31'd0, redirect_o}, 32'd1);
        @(negedge clk);
        // R13 idle cycle; redirect must drop
        op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h80, "R1 R13 idle");
        rd(12'hFC3, "R1 vector");
        rd(12'hFC0, "R2 status");

        // R10 ecall traps with enable clear; R8 R9 cause and pc
        op(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 32'h200, "R7 R10 ecall");
        rd(12'hFC1, "R8 ecall cause");
        rd(12'hFC2, "R9 epc");
        op(1, 0, 0, 0, 0, 0, 1, 0, 0, 1, 32'h204, "R10 ebreak");
        rd(12'hFC1, "R8 ebreak cause");

        // R5 alignment; R3 swap
        wr(12'h7C3, 32'h0000_1237, "R3 R5 vector write");
        rd(12'h7C3, "R5 vector");
        wr(12'h7C2, 32'hABCD_0003, "R5 epc write");
        rd(12'hFC2, "R5 epc");
        wr(12'h7C1, 32'hFFFF_FFFF, "R3 cause write");
        rd(12'hFC1, "R3 cause mask");
        wr(12'h7C0, 32'hFFFF_FFFC, "R3 status write");
        rd(12'hFC0, "R3 status mask");

        // R4 read-only alias ignores write
        wr(12'hFC3, 32'h0, "R4 alias write");
        rd(12'h7C3, "R4 vector kept");
        wr(12'hFC0, 32'h3, "R4 alias status");
        rd(12'hFC0, "R4 status kept");

        // R10 disabled interrupt ignored
        op(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h300, "R10 masked irq");
        wr(12'h7C0, 32'h1, "R3 enable");
        op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h304, "R10 R13 no valid");
        op(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h308, "R7 R8 irq taken");
        rd(12'hFC1, "R8 irq cause");
        rd(12'hFC2, "R9 irq epc");
        op(1, 1, 1, 12'hFC0, 0, 0, 0, 0, 0, 1, 32'h30C, "R2 live line");

        // R12 return
        op(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 32'h400, "R12 mret");
        rd(12'hFC0, "R12 enable restored");

        // R11 priority
        op(1, 0, 0, 0, 0, 1, 0, 0, 0, 1, 32'h500, "R11 ecall vs irq");
        rd(12'hFC1, "R11 ecall cause");
        op(1, 0, 0, 0, 0, 1, 1, 1, 0, 0, 32'h504, "R11 all sync");
        rd(12'hFC1, "R11 illegal wins");
        op(1, 0, 0, 0, 0, 1, 1, 0, 0, 0, 32'h508, "R11 ebreak wins");
        rd(12'hFC1, "R11 ebreak cause");

        // R6 bad CSR accesses
        op(1, 1, 0, 12'h7C1, 32'h5, 0, 0, 0, 0, 0, 32'h600, "R6 non-swap");
        rd(12'hFC1, "R6 cause");
        op(1, 1, 1, 12'h300, 32'h5, 0, 0, 0, 0, 0, 32'h604, "R6 unmapped");
        rd(12'hFC2, "R6 epc");

        // R13 trapped instruction drops its write and its return
        wr(12'h7C0, 32'h1, "R13 enable");
        op(1, 1, 1, 12'h7C3, 32'h8888, 0, 0, 0, 0, 1, 32'h700, "R13 csr cancelled");
        rd(12'hFC3, "R13 vector kept");
        wr(12'h7C0, 32'h3, "R13 enable again");
        op(1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h704, "R13 mret cancelled");
        rd(12'hFC0, "R13 status after");

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            int unsigned kind;
            logic v, csr, rw, ec, eb, il, mr, irq;
            logic [11:0] a;
            logic [31:0] wd, pc;
            kind = $urandom % 8;
            v   = ($urandom % 10) != 0;
            irq = ($urandom % 3) == 0;
            pc  = $urandom & 32'hFFFF_FFFC;
            wd  = $urandom;
            csr = 0; rw = 0; ec = 0; eb = 0; il = 0; mr = 0; a = 0;
            if (kind < 4) begin
                csr = 1;
                rw  = ($urandom % 10) != 0;
                if (($urandom % 100) < 85)
                    a = (($urandom % 2) ? 12'hFC0 : 12'h7C0) + 12'($urandom % 4);
                else
                    a = 12'($urandom);
                if (kind == 0) begin a = 12'h7C0; wd = 32'($urandom % 4); end
            end else if (kind == 4) begin
                mr = 1;
            end else if (kind == 5) begin
                ec = $urandom % 2; eb = $urandom % 2; il = $urandom % 2;
            end
            op(v, csr, rw, a, wd, ec, eb, il, mr, irq, pc,
               "R2 R3 R4 R6 R7 R8 R9 R10 R11 R12 R13 random");
        end
        chk_regs("R3 final regs");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule